// File: doc/BRIEF.md
# Serial Link Output Error Recovery Controller

This block is the transmit-side recovery sequencer of a serial packet link port. When the far end rejects a packet, the controller halts outbound traffic and asks the link partner for its input status by requesting a link-request control symbol. It then waits for the partner's link-response. If the response carries an acknowledge identifier inside the window of packets still outstanding, the controller resumes normal operation and hands that identifier to the transmitter, so retransmission starts from the right packet. If the identifier is outside that window, or if the partner stays silent through the full number of attempts, the controller gives up and enters a fatal-error state.

A sticky port-error status bit records every fatal entry, and also every unrecoverable-error pulse reported by the receive-side recovery logic. Software clears the bit by writing 1 to it. Clearing the bit does not restart the link. Only reset or an explicit software recovery strobe takes the controller out of the fatal-error state. Symbol encoding, CRC and the retransmission itself belong to neighbouring blocks.

Top module: `link_out_recovery`

## Requirements
- R1: After reset, stop_output, fatal_state, port_error, lreq_send and resume_valid are all 0. stop_output and fatal_state are never 1 together.
- R2: A pna_seen pulse during normal operation raises stop_output and a one-cycle lreq_send on the next clock.
- R3: During stop-output, a lresp_valid whose ackID lies inside the window returns the controller to normal operation on the next clock. On that clock the controller pulses resume_valid once and drives resume_ackid with the received ackID.
- R4: The window test runs modulo 2^ACKID_W (64 by default). An ackID is inside the window when (ackID - win_oldest) mod 64 <= (win_next - win_oldest) mod 64, and this holds across wraparound (for example oldest 60, next 3, ackID 1).
- R5: During stop-output, a lresp_valid whose ackID is outside the window sets fatal_state on the next clock.
- R6: During stop-output, each timeout_tick with no response re-sends the link-request (a new lreq_send pulse). This continues until MAX_TRIES (7) link-requests have gone out in total. The timeout that follows the seventh request sets fatal_state instead of re-sending.
- R7: port_error becomes 1 on the same clock on which fatal_state becomes 1.
- R8: An in_unrecov_err pulse sets port_error on the next clock and leaves the recovery state unchanged.
- R9: A write with csr_wr=1 and csr_wdata=1 clears port_error on the next clock. A write with csr_wdata=0 leaves port_error unchanged.
- R10: If a set event (fatal entry or in_unrecov_err) and a write-1 clear fall in the same cycle, port_error ends at 1.
- R11: fatal_state stays at 1 until sw_recover or reset, even after port_error has been cleared. A sw_recover pulse in fatal-error returns the controller to normal operation on the next clock.
- R12: During stop-output, when lresp_valid and timeout_tick are both present in one cycle, the response is acted on and the timeout is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pna_seen | input | 1 | Packet-not-accepted symbol received (pulse) |
| lresp_valid | input | 1 | Link-response received (pulse) |
| lresp_ackid | input | ACKID_W | ackID carried by the link-response |
| win_oldest | input | ACKID_W | Oldest outstanding ackID |
| win_next | input | ACKID_W | Next ackID to be sent |
| timeout_tick | input | 1 | Response timer expired (pulse) |
| in_unrecov_err | input | 1 | Unrecoverable-error pulse from the receive-side recovery |
| csr_wr | input | 1 | Software write strobe to the status bit |
| csr_wdata | input | 1 | Value written to the status bit (1 clears it) |
| sw_recover | input | 1 | Software recovery strobe that leaves fatal-error |
| lreq_send | output | 1 | Request to transmit a link-request/input-status symbol (pulse) |
| stop_output | output | 1 | Output halted while awaiting the link-response |
| fatal_state | output | 1 | Controller is in fatal-error |
| port_error | output | 1 | Sticky port-error status bit |
| resume_valid | output | 1 | A resume ackID is being reported (pulse) |
| resume_ackid | output | ACKID_W | ackID from which transmission resumes |

## Verification
Every output of this controller is registered, so each result appears exactly one clock after the input that causes it. This covers the stop-output entry with its link-request, every retry request, the resume report, fatal entry, and each change of the status bit. The bench drives inputs on the falling edge and queues each expected result with a due-cycle stamp one rising edge later. A monitor compares the result at the falling edge of that due cycle, which keeps the sample clear of the active edge. The seven-attempt limit is checked twice: the monitor checks each step, and a separate count of lreq_send pulses across the whole retry episode is checked at the end.

// File: rtl/link_out_recovery_pkg.sv
package link_out_recovery_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HALT = 2'd1,
      ST_DEAD = 2'd2
   } rec_state_e;

endpackage

// File: rtl/ackid_window_chk.sv
module ackid_window_chk #(
   parameter int ACKID_W = 6
) (
   input  logic [ACKID_W-1:0] ackid,
   input  logic [ACKID_W-1:0] oldest,
   input  logic [ACKID_W-1:0] next_id,
   output logic               in_window
);

   logic [ACKID_W-1:0] dist_ack;
   logic [ACKID_W-1:0] dist_span;

   // Subtraction truncated to ACKID_W bits gives modulo 2^ACKID_W distance
   always_comb begin
      dist_ack  = ackid - oldest;
      dist_span = next_id - oldest;
      in_window = (dist_ack <= dist_span);
   end

endmodule

// File: rtl/retry_tracker.sv
module retry_tracker #(
   parameter int MAX_TRIES = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic bump,
   input  logic clear,
   output logic at_limit
);

   localparam int CNT_W = $clog2(MAX_TRIES + 1);

   generate
      if (MAX_TRIES == 1) begin : g_single
         logic unused_in;
         assign unused_in = ^{clk, rst_n, start, bump, clear};
         assign at_limit  = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] tries_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tries_q <= '0;
            end else if (clear) begin
               tries_q <= '0;
            end else if (start) begin
               tries_q <= CNT_W'(1);
            end else if (bump) begin
               tries_q <= tries_q + CNT_W'(1);
            end
         end

         assign at_limit = (tries_q == CNT_W'(MAX_TRIES));
      end
   endgenerate

endmodule

// File: rtl/w1c_status.sv
module w1c_status (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic wr_en,
   input  logic wr_data,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hw_set) begin
         flag <= 1'b1;
      end else if (wr_en && wr_data) begin
         flag <= 1'b0;
      end
   end

endmodule

// File: rtl/link_out_recovery.sv
module link_out_recovery
   import link_out_recovery_pkg::*;
#(
   parameter int ACKID_W   = 6,
   parameter int MAX_TRIES = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pna_seen,
   input  logic               lresp_valid,
   input  logic [ACKID_W-1:0] lresp_ackid,
   input  logic [ACKID_W-1:0] win_oldest,
   input  logic [ACKID_W-1:0] win_next,
   input  logic               timeout_tick,
   input  logic               in_unrecov_err,
   input  logic               csr_wr,
   input  logic               csr_wdata,
   input  logic               sw_recover,
   output logic               lreq_send,
   output logic               stop_output,
   output logic               fatal_state,
   output logic               port_error,
   output logic               resume_valid,
   output logic [ACKID_W-1:0] resume_ackid
);

   generate
      if (ACKID_W < 2 || ACKID_W > 16) begin : g_bad_ackid_w
         $error("ACKID_W must be within 2..16");
      end
      if (MAX_TRIES < 1 || MAX_TRIES > 255) begin : g_bad_tries
         $error("MAX_TRIES must be within 1..255");
      end
   endgenerate

   rec_state_e state_q, state_d;
   logic       in_win;
   logic       at_limit;
   logic       cnt_start, cnt_bump, cnt_clear;
   logic       lreq_d, resume_d, enter_dead;

   ackid_window_chk #(.ACKID_W(ACKID_W)) i_win (
      .ackid     (lresp_ackid),
      .oldest    (win_oldest),
      .next_id   (win_next),
      .in_window (in_win)
   );

   retry_tracker #(.MAX_TRIES(MAX_TRIES)) i_retry (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cnt_start),
      .bump     (cnt_bump),
      .clear    (cnt_clear),
      .at_limit (at_limit)
   );

   w1c_status i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (enter_dead | in_unrecov_err),
      .wr_en   (csr_wr),
      .wr_data (csr_wdata),
      .flag    (port_error)
   );

   always_comb begin
      state_d    = state_q;
      lreq_d     = 1'b0;
      resume_d   = 1'b0;
      enter_dead = 1'b0;
      cnt_start  = 1'b0;
      cnt_bump   = 1'b0;
      cnt_clear  = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (pna_seen) begin
               state_d   = ST_HALT;
               lreq_d    = 1'b1;
               cnt_start = 1'b1;
            end
         end
         ST_HALT: begin
            if (lresp_valid) begin
               if (in_win) begin
                  state_d   = ST_RUN;
                  resume_d  = 1'b1;
                  cnt_clear = 1'b1;
               end else begin
                  state_d    = ST_DEAD;
                  enter_dead = 1'b1;
               end
            end else if (timeout_tick) begin
               if (at_limit) begin
                  state_d    = ST_DEAD;
                  enter_dead = 1'b1;
               end else begin
                  cnt_bump = 1'b1;
                  lreq_d   = 1'b1;
               end
            end
         end
         ST_DEAD: begin
            if (sw_recover) begin
               state_d   = ST_RUN;
               cnt_clear = 1'b1;
            end
         end
         default: begin
            state_d   = ST_RUN;
            cnt_clear = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_RUN;
         lreq_send    <= 1'b0;
         resume_valid <= 1'b0;
         resume_ackid <= '0;
      end else begin
         state_q      <= state_d;
         lreq_send    <= lreq_d;
         resume_valid <= resume_d;
         if (resume_d) begin
            resume_ackid <= lresp_ackid;
         end
      end
   end

   assign stop_output = (state_q == ST_HALT);
   assign fatal_state = (state_q == ST_DEAD);

endmodule

// File: rtl/link_out_recovery_chk.sv
module link_out_recovery_chk #(
   parameter int ACKID_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pna_seen,
   input logic               lresp_valid,
   input logic               in_unrecov_err,
   input logic               sw_recover,
   input logic               lreq_send,
   input logic               stop_output,
   input logic               fatal_state,
   input logic               port_error,
   input logic               resume_valid,
   input logic [ACKID_W-1:0] resume_ackid
);

   logic unused_ack;
   assign unused_ack = ^{resume_ackid, lresp_valid};

   AST_EXCL_STATES: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stop_output, fatal_state})); // R1

   AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_output && !fatal_state && pna_seen) |=> (stop_output && lreq_send)); // R2

   AST_RESUME_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      resume_valid |-> (!stop_output && !fatal_state && $past(stop_output))); // R3

   AST_LREQ_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      lreq_send |-> stop_output); // R6

   AST_FATAL_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fatal_state) |-> port_error); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      in_unrecov_err |=> port_error); // R10

   AST_FATAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal_state && !sw_recover) |=> fatal_state); // R11

endmodule

bind link_out_recovery link_out_recovery_chk #(.ACKID_W(ACKID_W)) i_chk (.*);

// File: tb/test_link_out_recovery.sv
module test_link_out_recovery;

   localparam int W     = 6;
   localparam int TRIES = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pna_seen = 1'b0, lresp_valid = 1'b0, timeout_tick = 1'b0;
   logic         in_unrecov_err = 1'b0, csr_wr = 1'b0, csr_wdata = 1'b0, sw_recover = 1'b0;
   logic [W-1:0] lresp_ackid = '0, win_oldest = '0, win_next = '0;
   logic         lreq_send, stop_output, fatal_state, port_error, resume_valid;
   logic [W-1:0] resume_ackid;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int lreq_cnt = 0;

   typedef struct {
      int          due;
      string       tag;
      logic        stop, fatal, perr, lreq, rv;
      logic [W-1:0] ra;
   } exp_t;

   exp_t q[$];

   // reference state: 0 normal, 1 stop-output, 2 fatal
   int   m_st = 0;
   int   m_tries = 0;
   logic m_perr = 1'b0;

   always #5 clk = ~clk;

   link_out_recovery #(.ACKID_W(W), .MAX_TRIES(TRIES)) i_link_out_recovery (
      .clk(clk), .rst_n(rst_n), .pna_seen(pna_seen), .lresp_valid(lresp_valid),
      .lresp_ackid(lresp_ackid), .win_oldest(win_oldest), .win_next(win_next),
      .timeout_tick(timeout_tick), .in_unrecov_err(in_unrecov_err), .csr_wr(csr_wr),
      .csr_wdata(csr_wdata), .sw_recover(sw_recover), .lreq_send(lreq_send),
      .stop_output(stop_output), .fatal_state(fatal_state), .port_error(port_error),
      .resume_valid(resume_valid), .resume_ackid(resume_ackid)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compares each expectation at the falling edge of its due cycle
   always @(negedge clk) begin
      if (rst_n && lreq_send) lreq_cnt++;
      while (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (stop_output !== e.stop || fatal_state !== e.fatal || port_error !== e.perr ||
             lreq_send !== e.lreq || resume_valid !== e.rv ||
             (e.rv && resume_ackid !== e.ra)) begin
            fails++;
            $display("FAIL %s: got stop=%b fatal=%b perr=%b lreq=%b rv=%b ack=%0d exp stop=%b fatal=%b perr=%b lreq=%b rv=%b ack=%0d",
                     e.tag, stop_output, fatal_state, port_error, lreq_send, resume_valid,
                     resume_ackid, e.stop, e.fatal, e.perr, e.lreq, e.rv, e.ra);
         end
      end
   end

   function automatic logic in_win(logic [W-1:0] a, logic [W-1:0] o, logic [W-1:0] n);
      logic [W-1:0] da, dn;
      da = a - o;
      dn = n - o;
      return da <= dn;
   endfunction

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input string tag, input logic p, input logic lv, input logic [W-1:0] la,
                       input logic to, input logic u, input logic cw, input logic cd,
                       input logic rc);
      exp_t e;
      logic set_ev;
      @(negedge clk);
      pna_seen = p; lresp_valid = lv; lresp_ackid = la; timeout_tick = to;
      in_unrecov_err = u; csr_wr = cw; csr_wdata = cd; sw_recover = rc;
      e.tag = tag; e.due = cyc + 1; e.lreq = 1'b0; e.rv = 1'b0; e.ra = la;
      set_ev = u;
      case (m_st)
         0: if (p) begin m_st = 1; m_tries = 1; e.lreq = 1'b1; end
         1: begin
            if (lv) begin
               if (in_win(la, win_oldest, win_next)) begin
                  m_st = 0; m_tries = 0; e.rv = 1'b1;
               end else begin
                  m_st = 2; set_ev = 1'b1;
               end
            end else if (to) begin
               if (m_tries == TRIES) begin m_st = 2; set_ev = 1'b1; end
               else begin m_tries++; e.lreq = 1'b1; end
            end
         end
         default: if (rc) begin m_st = 0; m_tries = 0; end
      endcase
      if (set_ev) m_perr = 1'b1;
      else if (cw && cd) m_perr = 1'b0;
      e.stop = (m_st == 1); e.fatal = (m_st == 2); e.perr = m_perr;
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, '0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (stop_output !== 0 || fatal_state !== 0 || port_error !== 0 || lreq_send !== 0 ||
          resume_valid !== 0) begin
         fails++;
         $display("FAIL R1 reset: got %b%b%b%b%b exp 00000", stop_output, fatal_state,
                  port_error, lreq_send, resume_valid);
      end
      rst_n = 1'b1;
      idle("R1 idle after reset");
      idle("R1 idle");

      // R2 stop-output entry, R3 in-window response
      win_oldest = 6'd10; win_next = 6'd14;
      step("R2 pna enters stop", 1, 0, '0, 0, 0, 0, 0, 0);
      idle("R2 lreq single pulse");
      step("R3 in-window resume", 0, 1, 6'd12, 0, 0, 0, 0, 0);
      idle("R3 resume pulse ends");

      // R4 wraparound window
      win_oldest = 6'd60; win_next = 6'd3;
      step("R2 pna again", 1, 0, '0, 0, 0, 0, 0, 0);
      step("R4 wrapped ackID 1 accepted", 0, 1, 6'd1, 0, 0, 0, 0, 0);
      step("R4 pna", 1, 0, '0, 0, 0, 0, 0, 0);
      step("R4 wrapped ackID 62 accepted", 0, 1, 6'd62, 0, 0, 0, 0, 0);

      // R5 out-of-window, R7 port error with fatal, R11 W1C leaves fatal
      step("R5 pna", 1, 0, '0, 0, 0, 0, 0, 0);
      step("R5 ackID 10 outside wrapped window", 0, 1, 6'd10, 0, 0, 0, 0, 0);
      step("R11 pna ignored in fatal", 1, 0, '0, 0, 0, 0, 0, 0);
      step("R11 clear bit keeps fatal", 0, 0, '0, 0, 0, 1, 1, 0);
      idle("R11 fatal still held");
      step("R11 sw recover", 0, 0, '0, 0, 0, 0, 0, 1);

      // R8 unrecoverable pulse, R9 W1C, R10 set wins
      step("R8 unrecov sets bit", 0, 0, '0, 0, 1, 0, 0, 0);
      step("R9 write 0 no effect", 0, 0, '0, 0, 0, 1, 0, 0);
      step("R9 write 1 clears", 0, 0, '0, 0, 0, 1, 1, 0);
      step("R10 set beats clear", 0, 0, '0, 0, 1, 1, 1, 0);
      step("R9 clear again", 0, 0, '0, 0, 0, 1, 1, 0);

      // R12 response beats timeout
      win_oldest = 6'd20; win_next = 6'd25;
      step("R12 pna", 1, 0, '0, 0, 0, 0, 0, 0);
      step("R12 timeout retry", 0, 0, '0, 1, 0, 0, 0, 0);
      step("R12 response with timeout", 0, 1, 6'd25, 1, 0, 0, 0, 0);
      idle("R12 idle");

      // R6 seven attempts then fatal, R10 fatal entry with clear
      repeat (2) @(negedge clk);
      lreq_cnt = 0;
      step("R6 pna first request", 1, 0, '0, 0, 0, 0, 0, 0);
      for (int t = 1; t < TRIES; t++) begin
         idle("R6 waiting");
         step("R6 timeout resend", 0, 0, '0, 1, 0, 0, 0, 0);
      end
      idle("R6 still in stop after seventh request");
      step("R10 final timeout fatal with clear", 0, 0, '0, 1, 0, 1, 1, 0);
      idle("R7 fatal holds port error");
      repeat (3) @(negedge clk);
      checks++;
      if (lreq_cnt != TRIES) begin
         fails++;
         $display("FAIL R6: link-requests sent %0d expected %0d", lreq_cnt, TRIES);
      end
      step("R11 recover", 0, 0, '0, 0, 0, 0, 0, 1);
      idle("R11 back to normal");
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule